// File: doc/BRIEF.md
# USB 1.x Host Controller Frame and Register Core

This block is the register core of a simple full-speed USB host controller. A 16-byte window on a plain 32-bit read/write bus holds the command, status and interrupt-enable registers, the frame index, the frame list base address and the start-of-frame adjustment. Writes are byte-lane qualified. Read data is a combinational function of the word address.

A one-cycle enable at the 12 MHz bit rate clocks a frame timer. The frame lasts a fixed 11936 bit times plus a 7-bit adjustment. While the run bit is set, each frame boundary advances an 11-bit frame index. When run is cleared, the controller reports itself halted at the next boundary.

Single-cycle event inputs stand in for the transfer engine. They set the status flags, and software clears those flags by writing ones. The interrupt output rises whenever an enabled cause is pending.

Top module: `usbh_frame_core`

## Requirements
- R1: Word address `bus_addr[3:2]` selects the register. Word 0 carries command in bits 15:0 and status in bits 31:16. Word 1 carries interrupt enable in bits 15:0 and the frame index in bits 31:16. Word 2 is the frame list base. Word 3 bits 7:0 hold the SOF adjustment. After reset these words read 0x00200000, 0x00000000, 0x00000000 and 0x00000040.
- R2: Command bits 7:0 are read/write: 0 run, 1 controller reset, 2 global reset, 3 suspend, 4 resume, 5 debug, 6 configured, 7 packet size. Bits 15:8 always read zero.
- R3: A frame lasts 11936 + A enabled bit-clock cycles, where A is the 7-bit SOF adjustment. Write data bit 7 of that register is dropped. One `frame_tick` pulse marks each boundary, and a new A applies from the boundary at which it is written.
- R4: While run is 1, the frame index (11 bits) increments modulo 2048 at each boundary. Status bits 15:11 of word 1's upper half read zero, and software may load the index.
- R5: Status bit 5 (halted) is 1 out of reset. Writing run = 1 clears it. After run is cleared, it is set at the next frame boundary, the index does not advance, and the frame timer then stops.
- R6: Status bits 0–5 are cleared by writing 1 and unaffected by writing 0. Event inputs set bit 0 (complete or short), bit 1 (error), bit 2 (resume), bit 3 (bus error) and bit 4 (process error). A set in the same cycle as a clear wins.
- R7: Interrupt enable bits 3:0 are read/write: 0 error, 1 resume, 2 complete, 3 short. Bits 15:4 read zero. `irq` = (status0 & (en2 | en3)) | (status1 & en0) | (status2 & en1).
- R8: The frame list base stores bits 31:12 only. Bits 11:0 always read zero.
- R9: Writing command bit 1 = 1 sets that bit for exactly one cycle. At the following edge, every register returns to its reset value.
- R10: Only byte lanes whose `bus_be` bit is 1 are written. A lane holding only reserved bits changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle enable at the 12 MHz bit rate |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address in the window |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| ev_complete | input | 1 | Transfer completed with interrupt request |
| ev_short | input | 1 | Short packet seen |
| ev_error | input | 1 | Timeout or CRC error |
| ev_resume | input | 1 | Remote resume received |
| ev_bus_err | input | 1 | System bus error |
| ev_proc_err | input | 1 | Schedule processing error |
| frame_tick | output | 1 | One-cycle pulse at each frame boundary |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the exact spacing of boundary pulses at three adjustment values, including one written with bit 7 set. A timer that is off by one, or that keeps bit 7, would show a period of 11999, 12001 or 12063 + 128.

It loads the frame index at 2047 and checks the next boundary. A design without the modulo wrap would show 2048 or would leak into the reserved bits. It also stops the run and checks that halted appears only at the boundary, with the index frozen, and that the timer then stays silent. A design that halts at once or keeps counting fails there.

On the status side, the bench drives an event and a clear in the same cycle, gates each interrupt cause with its enable, and checks that controller reset holds for exactly one cycle before every register reverts.

// File: rtl/usbh_pkg.sv
package usbh_pkg;

  localparam int unsigned FRAME_BASE_LEN = 11936;
  localparam int unsigned SOF_BITS       = 7;
  localparam int unsigned SOF_DEFAULT    = 64;
  localparam int unsigned FRNUM_BITS     = 11;
  localparam int unsigned FLB_LSB        = 12;
  localparam int unsigned FLB_BITS       = 32 - FLB_LSB;

  typedef enum logic [1:0] {
    W_CMD_STS  = 2'd0,
    W_IE_FRNUM = 2'd1,
    W_FLBASE   = 2'd2,
    W_SOF      = 2'd3
  } word_sel_e;

  // Number of enabled bit-clock cycles in one frame.
  function automatic int unsigned frame_len(input int unsigned base, input int unsigned adj);
    return base + adj;
  endfunction

  // Next frame index, wrapped to w bits.
  function automatic logic [15:0] frame_next(input logic [15:0] cur, input int unsigned w);
    logic [15:0] mask;
    mask = 16'((32'd1 << w) - 32'd1);
    return (cur + 16'd1) & mask;
  endfunction

  // Merge a two-lane write into a 16-bit value.
  function automatic logic [15:0] lane_merge16(input logic [15:0] cur, input logic [15:0] val,
                                               input logic [1:0] be);
    return {be[1] ? val[15:8] : cur[15:8], be[0] ? val[7:0] : cur[7:0]};
  endfunction

  // Interrupt cause evaluation: sts = {resume, error, usb_int}, en = {short, ioc, resume, err}.
  function automatic logic irq_pending(input logic [2:0] sts, input logic [3:0] en);
    return (sts[0] & (en[2] | en[3])) | (sts[1] & en[0]) | (sts[2] & en[1]);
  endfunction

endpackage

// File: rtl/usbh_sof_timer.sv
module usbh_sof_timer
  import usbh_pkg::*;
#(
  parameter int unsigned BASE_LEN = FRAME_BASE_LEN,
  parameter int unsigned SOF_W    = SOF_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             active,
  input  logic             bit_en,
  input  logic [SOF_W-1:0] sof_val,
  output logic             frame_tick
);
  localparam int unsigned MAX_LEN = BASE_LEN + (1 << SOF_W);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             at_end;

  assign last_cnt   = CNT_W'(frame_len(BASE_LEN, 32'(sof_val)) - 1);
  assign at_end     = (cnt_q >= last_cnt);
  assign frame_tick = active & bit_en & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (soft_rst || !active) begin
      cnt_q <= '0;
    end else if (bit_en) begin
      cnt_q <= at_end ? '0 : CNT_W'(cnt_q + 1'b1);
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> !frame_tick); // R3

  AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |-> (bit_en && active)); // R3

endmodule

// File: rtl/usbh_frame_ctr.sv
module usbh_frame_ctr
  import usbh_pkg::*;
#(
  parameter int unsigned FRNUM_W = FRNUM_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               frame_tick,
  input  logic               run,
  input  logic               ld_en,
  input  logic [1:0]         ld_be,
  input  logic [15:0]        ld_val,
  output logic [FRNUM_W-1:0] frnum
);
  logic [FRNUM_W-1:0] frnum_q;
  logic [15:0]        cur16;
  logic               advance;

  assign cur16   = 16'(frnum_q);
  assign advance = frame_tick & run;
  assign frnum   = frnum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frnum_q <= '0;
    end else if (soft_rst) begin
      frnum_q <= '0;
    end else if (ld_en) begin
      frnum_q <= FRNUM_W'(lane_merge16(cur16, ld_val, ld_be));
    end else if (advance) begin
      frnum_q <= FRNUM_W'(frame_next(cur16, FRNUM_W));
    end
  end

  AST_FRNUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !ld_en && !soft_rst) |=> (frnum_q == FRNUM_W'($past(frnum_q) + 1'b1))); // R4

  AST_FRNUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !ld_en && !soft_rst) |=> $stable(frnum_q)); // R4

endmodule

// File: rtl/usbh_reg_bank.sv
module usbh_reg_bank
  import usbh_pkg::*;
#(
  parameter int unsigned SOF_W   = SOF_BITS,
  parameter int unsigned SOF_RST = SOF_DEFAULT,
  parameter int unsigned FRNUM_W = FRNUM_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [3:0]         bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [4:0]         ev_set,
  input  logic               frame_tick,
  input  logic [FRNUM_W-1:0] frnum,
  output logic               run,
  output logic               halted,
  output logic               hc_rst,
  output logic [SOF_W-1:0]   sof_val,
  output logic               frnum_ld,
  output logic [1:0]         frnum_ld_be,
  output logic [15:0]        frnum_ld_val,
  output logic [2:0]         sts_irq,
  output logic [3:0]         ie
);
  logic [7:0]          cmd_q;
  logic [5:0]          sts_q, sts_d;
  logic [3:0]          ie_q;
  logic [FLB_BITS-1:0] flb_q;
  logic [SOF_W-1:0]    sof_q;

  word_sel_e word;
  logic wr_cmd, wr_sts, wr_ie, wr_flb, wr_sof;
  logic run_set, halt_set;
  logic [5:0] sts_clr;

  assign word    = word_sel_e'(bus_addr[3:2]);
  assign wr_cmd  = bus_wr && (word == W_CMD_STS)  && bus_be[0];
  assign wr_sts  = bus_wr && (word == W_CMD_STS)  && bus_be[2];
  assign wr_ie   = bus_wr && (word == W_IE_FRNUM) && bus_be[0];
  assign wr_flb  = bus_wr && (word == W_FLBASE);
  assign wr_sof  = bus_wr && (word == W_SOF)      && bus_be[0];

  assign frnum_ld     = bus_wr && (word == W_IE_FRNUM) && (|bus_be[3:2]);
  assign frnum_ld_be  = bus_be[3:2];
  assign frnum_ld_val = bus_wdata[31:16];

  assign run_set  = wr_cmd && bus_wdata[0];
  assign halt_set = frame_tick && !cmd_q[0];
  assign sts_clr  = wr_sts ? bus_wdata[21:16] : 6'd0;

  always_comb begin
    sts_d = (sts_q & ~sts_clr) | {halt_set, ev_set};
    if (run_set) sts_d[5] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      sts_q <= 6'b100000;
      ie_q  <= '0;
      flb_q <= '0;
      sof_q <= SOF_W'(SOF_RST);
    end else if (cmd_q[1]) begin
      cmd_q <= '0;
      sts_q <= 6'b100000;
      ie_q  <= '0;
      flb_q <= '0;
      sof_q <= SOF_W'(SOF_RST);
    end else begin
      sts_q <= sts_d;
      if (wr_cmd) cmd_q <= bus_wdata[7:0];
      if (wr_ie)  ie_q  <= bus_wdata[3:0];
      if (wr_sof) sof_q <= bus_wdata[SOF_W-1:0];
      if (wr_flb) begin
        if (bus_be[1]) flb_q[3:0]   <= bus_wdata[15:12];
        if (bus_be[2]) flb_q[11:4]  <= bus_wdata[23:16];
        if (bus_be[3]) flb_q[19:12] <= bus_wdata[31:24];
      end
    end
  end

  always_comb begin
    case (word)
      W_CMD_STS:  bus_rdata = {10'd0, sts_q, 8'd0, cmd_q};
      W_IE_FRNUM: bus_rdata = {{(16-FRNUM_W){1'b0}}, frnum, 12'd0, ie_q};
      W_FLBASE:   bus_rdata = {flb_q, {FLB_LSB{1'b0}}};
      W_SOF:      bus_rdata = {{(32-SOF_W){1'b0}}, sof_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign run     = cmd_q[0];
  assign halted  = sts_q[5];
  assign hc_rst  = cmd_q[1];
  assign sof_val = sof_q;
  assign sts_irq = sts_q[2:0];
  assign ie      = ie_q;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[11:8]};

  AST_HCRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[1] |=> !cmd_q[1]); // R9

  AST_HCRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[1] |=> (ie_q == 4'd0 && flb_q == '0 && sof_q == SOF_W'(SOF_RST) && sts_q == 6'b100000)); // R9

  AST_HALT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !cmd_q[0] && !cmd_q[1] && !run_set) |=> sts_q[5]); // R5

  AST_NO_SPURIOUS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set == 5'd0 && !frame_tick && !cmd_q[1]) |=> ((sts_q & ~$past(sts_q)) == 6'd0)); // R6

endmodule

// File: rtl/usbh_frame_core.sv
module usbh_frame_core
  import usbh_pkg::*;
#(
  parameter int unsigned BASE_LEN = FRAME_BASE_LEN,
  parameter int unsigned SOF_W    = SOF_BITS,
  parameter int unsigned SOF_RST  = SOF_DEFAULT,
  parameter int unsigned FRNUM_W  = FRNUM_BITS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ev_complete,
  input  logic        ev_short,
  input  logic        ev_error,
  input  logic        ev_resume,
  input  logic        ev_bus_err,
  input  logic        ev_proc_err,
  output logic        frame_tick,
  output logic        irq
);
  logic               run, halted, hc_rst, frnum_ld;
  logic [SOF_W-1:0]   sof_val;
  logic [1:0]         frnum_ld_be;
  logic [15:0]        frnum_ld_val;
  logic [FRNUM_W-1:0] frnum;
  logic [2:0]         sts_irq;
  logic [3:0]         ie;
  logic [4:0]         ev_set;
  logic               timer_active;

  assign ev_set       = {ev_proc_err, ev_bus_err, ev_resume, ev_error, ev_complete | ev_short};
  assign timer_active = run | ~halted;

  usbh_reg_bank #(.SOF_W(SOF_W), .SOF_RST(SOF_RST), .FRNUM_W(FRNUM_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_set(ev_set), .frame_tick(frame_tick),
    .frnum(frnum), .run(run), .halted(halted), .hc_rst(hc_rst), .sof_val(sof_val),
    .frnum_ld(frnum_ld), .frnum_ld_be(frnum_ld_be), .frnum_ld_val(frnum_ld_val),
    .sts_irq(sts_irq), .ie(ie)
  );

  usbh_sof_timer #(.BASE_LEN(BASE_LEN), .SOF_W(SOF_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(hc_rst), .active(timer_active), .bit_en(bit_en),
    .sof_val(sof_val), .frame_tick(frame_tick)
  );

  usbh_frame_ctr #(.FRNUM_W(FRNUM_W)) frctr_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(hc_rst), .frame_tick(frame_tick), .run(run),
    .ld_en(frnum_ld), .ld_be(frnum_ld_be), .ld_val(frnum_ld_val), .frnum(frnum)
  );

  assign irq = irq_pending(sts_irq, ie);

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_irq != 3'd0 && ie != 4'd0)); // R7

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !run) |-> !frame_tick); // R5

endmodule

// File: tb/usbh_frame_core_tb.sv
module usbh_frame_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 180000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_complete = 0, ev_short = 0, ev_error = 0, ev_resume = 0;
  logic        ev_bus_err = 0, ev_proc_err = 0;
  logic        frame_tick, irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbh_frame_core dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_complete(ev_complete), .ev_short(ev_short), .ev_error(ev_error),
    .ev_resume(ev_resume), .ev_bus_err(ev_bus_err), .ev_proc_err(ev_proc_err),
    .frame_tick(frame_tick), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!frame_tick);
  endtask

  task automatic t_reset_values();
    logic [31:0] d;
    rd(4'h0, d); check("R1 word0 reset", d, 32'h0020_0000);
    rd(4'h4, d); check("R1 word1 reset", d, 32'h0);
    rd(4'h8, d); check("R1 word2 reset", d, 32'h0);
    rd(4'hC, d); check("R1 word3 reset", d, 32'h40);
    check("R7 irq reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_command();
    logic [31:0] d;
    wr(4'h0, 32'h0000_FFFC, 4'b0011);
    rd(4'h0, d); check("R2 cmd bits, reserved zero", d & 32'hFFFF, 32'h00FC);
    wr(4'h0, 32'h0000_0000, 4'b0010);
    rd(4'h0, d); check("R10 cmd lane1 write ignored", d & 32'hFFFF, 32'h00FC);
    wr(4'h0, 32'h0000_0000, 4'b0001);
    rd(4'h0, d); check("R2 cmd cleared", d & 32'hFFFF, 32'h0);
  endtask

  task automatic t_base_lanes();
    logic [31:0] d;
    wr(4'h8, 32'hFFFF_FFFF, 4'b1100);
    rd(4'h8, d); check("R10 base upper lanes", d, 32'hFFFF_0000);
    wr(4'h8, 32'h1234_ABCD, 4'b0011);
    rd(4'h8, d); check("R8 base low bits zero", d, 32'hFFFF_A000);
  endtask

  task automatic t_status_irq();
    logic [31:0] d;
    wr(4'h4, 32'h0000_00F4, 4'b0001);
    rd(4'h4, d); check("R7 ie reserved zero", d & 32'hFFFF, 32'h0004);
    ev_complete = 1; @(negedge clk); ev_complete = 0;
    rd(4'h0, d); check("R6 complete sets bit0", d >> 16, 32'h21);
    check("R7 irq on complete", {31'd0, irq}, 32'd1);
    wr(4'h0, 32'h0000_0000, 4'b0100);
    rd(4'h0, d); check("R6 write zero no effect", d >> 16, 32'h21);
    wr(4'h0, 32'h0001_0000, 4'b0100);
    rd(4'h0, d); check("R6 w1c bit0", d >> 16, 32'h20);
    check("R7 irq drops", {31'd0, irq}, 32'd0);
    ev_error = 1; @(negedge clk); ev_error = 0;
    rd(4'h0, d); check("R6 error sets bit1", d >> 16, 32'h22);
    check("R7 error masked", {31'd0, irq}, 32'd0);
    wr(4'h4, 32'h0000_0005, 4'b0001);
    check("R7 error enabled", {31'd0, irq}, 32'd1);
    ev_bus_err = 1; ev_proc_err = 1; @(negedge clk); ev_bus_err = 0; ev_proc_err = 0;
    rd(4'h0, d); check("R6 bus/proc errors", d >> 16, 32'h3A);
    wr(4'h0, 32'h003F_0000, 4'b0100);
    rd(4'h0, d); check("R6 clear all", d >> 16, 32'h00);
    check("R7 irq idle", {31'd0, irq}, 32'd0);
    ev_resume = 1;
    wr(4'h0, 32'h0004_0000, 4'b0100);
    ev_resume = 0;
    rd(4'h0, d); check("R6 set beats clear", d >> 16, 32'h04);
    check("R7 resume masked", {31'd0, irq}, 32'd0);
    wr(4'h4, 32'h0000_0002, 4'b0001);
    check("R7 resume enabled", {31'd0, irq}, 32'd1);
    ev_short = 1; @(negedge clk); ev_short = 0;
    wr(4'h4, 32'h0000_0008, 4'b0001);
    check("R7 short enable on bit0", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_hc_reset();
    logic [31:0] d;
    wr(4'hC, 32'h0000_0011, 4'b0001);
    wr(4'h0, 32'h0000_0042, 4'b0001);
    rd(4'h0, d); check("R9 reset bit visible one cycle", d & 32'hFFFF, 32'h0042);
    @(negedge clk);
    rd(4'h0, d); check("R9 cmd/status restored", d, 32'h0020_0000);
    rd(4'h4, d); check("R9 ie/frnum restored", d, 32'h0);
    rd(4'h8, d); check("R9 base restored", d, 32'h0);
    rd(4'hC, d); check("R9 sof restored", d, 32'h40);
    check("R9 irq cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic measure_after_sof(input logic [7:0] v, output int p);
    wr(4'hC, {24'd0, v}, 4'b0001);
    p = 1;
    while (!frame_tick) begin @(negedge clk); p++; end
  endtask

  task automatic t_frame_timing();
    logic [31:0] d;
    int p;
    wr(4'h0, 32'h0000_0001, 4'b0001);
    rd(4'h0, d); check("R5 run clears halted", (d >> 21) & 1, 32'd0);
    wait_tick();
    p = 0;
    do begin @(negedge clk); p++; end while (!frame_tick);
    check("R3 period default", p, 32'd12000);
    measure_after_sof(8'h80, p);
    check("R3 period adj 0 (bit7 dropped)", p, 32'd11936);
    rd(4'hC, d); check("R3 sof readback", d, 32'h0);
    measure_after_sof(8'hFF, p);
    check("R3 period adj 127", p, 32'd12063);
    rd(4'hC, d); check("R3 sof 7 bits", d, 32'h7F);
    @(negedge clk);
    rd(4'h4, d); check("R4 four frames counted", d >> 16, 32'd4);
  endtask

  task automatic t_frame_wrap();
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_0000, 4'b1100);
    rd(4'h4, d); check("R4 index reserved zero", d >> 16, 32'h07FF);
    wait_tick(); @(negedge clk);
    rd(4'h4, d); check("R4 wrap modulo 2048", d >> 16, 32'h0);
  endtask

  task automatic t_halt();
    logic [31:0] d, f;
    bit seen;
    rd(4'h4, f);
    wr(4'h0, 32'h0000_0000, 4'b0001);
    rd(4'h0, d); check("R5 halted not immediate", (d >> 21) & 1, 32'd0);
    wait_tick(); @(negedge clk);
    rd(4'h0, d); check("R5 halted at boundary", (d >> 21) & 1, 32'd1);
    rd(4'h4, d); check("R5 index frozen when stopped", d >> 16, f >> 16);
    seen = 0;
    for (int i = 0; i < 13000; i++) begin
      @(negedge clk);
      if (frame_tick) seen = 1;
    end
    check("R5 timer stopped", {31'd0, seen}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_values();
    t_command();
    t_base_lanes();
    t_status_irq();
    t_hc_reset();
    t_frame_timing();
    t_frame_wrap();
    t_halt();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule